// File: doc/BRIEF.md
# Flash write-status reporting unit

This block stands in for the read side of a parallel NOR flash while the flash is busy with an internal write. A one-cycle start pulse launches an operation: a word program, a short (sector or block) erase or a long (whole-array) erase. The pulse carries a two-bit kind code and, for a program, the target word. The unit then holds a busy output high for a number of clock cycles fixed per kind by a parameter. During that time every read strobe returns a synthesised status word instead of array contents. After completion, reads return the word that now sits at the location.

Two status bits carry the progress. Bit 7 is a completion flag: for a program it is the inverse of the target word's bit 7, and for an erase it is 0. Bit 6 flips on every read taken while busy, so two successive reads that agree show that the write has ended. Every other bit of a busy read is undefined and carries no meaning. While an operation runs, every further start pulse is dropped.

The controller has three states. ST_IDLE waits for a start. ST_PROG_BUSY and ST_ERASE_BUSY time an operation. The transition T_START_PROG goes from ST_IDLE to ST_PROG_BUSY when kind 00 is accepted. T_START_ERASE goes from ST_IDLE to ST_ERASE_BUSY when kind 01 or 10 is accepted. T_FINISH returns either busy state to ST_IDLE when the cycle counter reaches zero. On T_FINISH the unit stores the finished word: the programmed data for a program, and all ones for an erase.

Top module: `flash_wstat`

## Requirements
- R1: After reset, busy is 0 and rd_data is 16'h0000. A read taken before any operation returns 16'hFFFF, the erased value.
- R2: A start pulse seen in ST_IDLE with kind 2'b00 (program), 2'b01 (short erase) or 2'b10 (long erase) raises busy in the next cycle. Busy then stays high for exactly PROG_CYC, SERASE_CYC or CERASE_CYC cycles respectively.
- R3: A start pulse with kind 2'b11 has no effect: busy stays low and idle reads keep returning the previously stored word.
- R4: A start pulse that arrives while busy is ignored. The running operation keeps its length, and its result is the one stored.
- R5: During a program, bit 7 of every read equals the inverse of bit 7 of the word being programmed.
- R6: During an erase of either length, bit 7 of every read is 0.
- R7: During any operation, bit 6 of the first read is 0, and each later read returns the inverse of the read before it. Reads taken in consecutive cycles or spread out behave the same, and every new operation starts again at 0.
- R8: After a program completes, every read returns the programmed word, and successive reads return the same value.
- R9: After an erase completes, every read returns 16'hFFFF.
- R10: rd_data changes only in the cycle after a read strobe. Without a strobe it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle request to begin an operation |
| op_kind | input | 2 | Operation kind: 00 program, 01 short erase, 10 long erase, 11 reserved |
| op_data | input | DW | Word to program, sampled with op_start |
| rd_stb | input | 1 | Read strobe; rd_data updates in the next cycle |
| rd_data | output | DW | Status word while busy, stored word otherwise |
| busy | output | 1 | High while an internal operation runs |

## Verification
The in-RTL properties check the following every cycle:
- that an accepted start raises busy and that a reserved or overlapping start changes nothing;
- that a busy program read inverts bit 7 and a busy erase read forces it to 0;
- that back-to-back busy reads alternate bit 6;
- that rd_data holds without a strobe;
- that idle reads return the stored word, which is filled correctly on T_FINISH.

Some behaviour only the bench scenarios can show. These are the exact busy length for each kind, the reset of the toggle sequence to 0 at each new operation (which matters after an odd number of reads), and the toggle alternation when busy reads are spread out. They also include the end-to-end result of a program across many data patterns and read rates, and of an operation that received a second start pulse.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

    typedef enum logic [1:0] {
        OP_PROG    = 2'b00,
        OP_ERASE_S = 2'b01,
        OP_ERASE_C = 2'b10,
        OP_RSVD    = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_PROG_BUSY  = 2'b01,
        ST_ERASE_BUSY = 2'b10
    } wstat_state_e;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

endpackage

// File: rtl/flash_wstat_timer.sv
module flash_wstat_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2: a loaded count never sits still while it is non-zero
    p_count_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/flash_wstat_ctrl.sv
module flash_wstat_ctrl
    import flash_wstat_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CW         = 8,
    parameter int PROG_CYC   = 20,
    parameter int SERASE_CYC = 50,
    parameter int CERASE_CYC = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [1:0]    op_kind,
    input  logic [DW-1:0] op_data,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          busy,
    output logic          is_erase,
    output logic          accept,
    output logic [DW-1:0] tgt_q,
    output logic [DW-1:0] word_q
);

    wstat_state_e state_q, state_d;
    op_kind_e     kind;

    assign kind = op_kind_e'(op_kind);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_START_PROG, T_START_ERASE, T_FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    if (kind == OP_PROG) begin
                        state_d = ST_PROG_BUSY;
                    end else if (kind == OP_ERASE_S || kind == OP_ERASE_C) begin
                        state_d = ST_ERASE_BUSY;
                    end
                end
            end
            ST_PROG_BUSY, ST_ERASE_BUSY: begin
                if (expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        is_erase = (state_q == ST_ERASE_BUSY);
        accept   = (state_q == ST_IDLE) && op_start && (kind != OP_RSVD);
        load     = accept;
        unique case (kind)
            OP_PROG:    load_val = CW'(PROG_CYC - 1);
            OP_ERASE_S: load_val = CW'(SERASE_CYC - 1);
            OP_ERASE_C: load_val = CW'(CERASE_CYC - 1);
            default:    load_val = '0;
        endcase
    end

    // captured target and finished word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            word_q <= '1;
        end else begin
            if (accept) begin
                tgt_q <= op_data;
            end
            if (state_q != ST_IDLE && expired) begin
                word_q <= (state_q == ST_PROG_BUSY) ? tgt_q : '1;
            end
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_start && op_kind != 2'b11) |=> busy);

    p_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_start && op_kind == 2'b11) |=> (!busy && $stable(word_q)));

    p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_start) |=> $stable(tgt_q));

    p_prog_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(state_q == ST_PROG_BUSY)) |-> (word_q == tgt_q));

    p_erase_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(state_q == ST_ERASE_BUSY)) |-> (word_q == '1));

endmodule

// File: rtl/flash_wstat_rdport.sv
module flash_wstat_rdport
    import flash_wstat_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          busy,
    input  logic          is_erase,
    input  logic          clr_tog,
    input  logic [DW-1:0] tgt_word,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] rd_data
);

    logic          tog_q;
    logic [DW-1:0] stat_word;
    logic [DW-1:0] rd_q;

    always_comb begin
        stat_word           = '0;
        stat_word[POLL_BIT] = is_erase ? 1'b0 : ~tgt_word[POLL_BIT];
        stat_word[TOG_BIT]  = tog_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
            rd_q  <= '0;
        end else begin
            if (clr_tog) begin
                tog_q <= 1'b0;
            end else if (rd_stb && busy) begin
                tog_q <= ~tog_q;
            end
            if (rd_stb) begin
                rd_q <= busy ? stat_word : word;
            end
        end
    end

    assign rd_data = rd_q;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    p_prog_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && !is_erase) |=> (rd_data[POLL_BIT] == !$past(tgt_word[POLL_BIT])));

    p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && is_erase) |=> (rd_data[POLL_BIT] == 1'b0));

    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && $past(rd_stb && busy)) |=> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

    p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> (rd_data == $past(word)));

endmodule

// File: rtl/flash_wstat.sv
module flash_wstat #(
    parameter int DW         = 16,
    parameter int PROG_CYC   = 20,
    parameter int SERASE_CYC = 50,
    parameter int CERASE_CYC = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [1:0]    op_kind,
    input  logic [DW-1:0] op_data,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_data,
    output logic          busy
);

    localparam int MAX_AB = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
    localparam int MAXC   = (MAX_AB > CERASE_CYC) ? MAX_AB : CERASE_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    logic          is_erase;
    logic          accept;
    logic [DW-1:0] tgt_q;
    logic [DW-1:0] word_q;

    flash_wstat_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    flash_wstat_ctrl #(
        .DW         (DW),
        .CW         (CW),
        .PROG_CYC   (PROG_CYC),
        .SERASE_CYC (SERASE_CYC),
        .CERASE_CYC (CERASE_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_data  (op_data),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .busy     (busy),
        .is_erase (is_erase),
        .accept   (accept),
        .tgt_q    (tgt_q),
        .word_q   (word_q)
    );

    flash_wstat_rdport #(.DW(DW)) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .busy     (busy),
        .is_erase (is_erase),
        .clr_tog  (accept),
        .tgt_word (tgt_q),
        .word     (word_q),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/flash_wstat_tb.sv
module flash_wstat_tb;

    localparam int CLK_P = 10;
    localparam int PC    = 5;
    localparam int SC    = 9;
    localparam int CC    = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [15:0] op_data = 16'h0000;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;
    logic        busy;

    int checks = 0;
    int errors = 0;
    logic [15:0] cur_word = 16'hFFFF;

    always #(CLK_P / 2) clk = ~clk;

    flash_wstat #(
        .DW(16), .PROG_CYC(PC), .SERASE_CYC(SC), .CERASE_CYC(CC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_data(op_data), .rd_stb(rd_stb), .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [15:0] val);
        @(negedge clk);
        rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        val = rd_data;
    endtask

    // mode 0: no busy reads, 1: every cycle, 2: every other cycle
    task automatic run_op(input logic [1:0] kind, input logic [15:0] data,
                          input int mode, input bit inject);
        int n;
        int exp_len;
        logic tog;
        logic [15:0] v;
        @(negedge clk);
        op_start = 1'b1; op_kind = kind; op_data = data;
        @(posedge clk);
        @(negedge clk);
        op_start = 1'b0; op_kind = 2'b00; op_data = 16'h0000;
        exp_len = (kind == 2'b00) ? PC : (kind == 2'b01) ? SC : CC;
        n = 0;
        tog = 1'b0;
        while (busy === 1'b1 && n < 400) begin
            if (inject && n == 1) begin
                op_start = 1'b1;
                op_kind  = (kind == 2'b00) ? 2'b01 : 2'b00;
                op_data  = ~data;
            end
            if (mode == 1 || (mode == 2 && (n % 2) == 0)) rd_stb = 1'b1;
            @(posedge clk);
            @(negedge clk);
            op_start = 1'b0;
            if (rd_stb) begin
                rd_stb = 1'b0;
                if (kind == 2'b00)
                    chk("R5 poll bit during program", {31'd0, rd_data[7]}, {31'd0, ~data[7]});
                else
                    chk("R6 poll bit during erase", {31'd0, rd_data[7]}, 32'd0);
                chk("R7 toggle bit", {31'd0, rd_data[6]}, {31'd0, tog});
                tog = ~tog;
            end
            n++;
        end
        if (inject) chk("R4 busy length with ignored start", n, exp_len);
        else        chk("R2 busy length", n, exp_len);
        cur_word = (kind == 2'b00) ? data : 16'hFFFF;
        do_read(v);
        if (kind == 2'b00) chk("R8 word after program", {16'd0, v}, {16'd0, cur_word});
        else               chk("R9 word after erase", {16'd0, v}, 32'h0000FFFF);
        do_read(v);
        chk(inject ? "R4 result of first op kept" : "R8 repeat read stable",
            {16'd0, v}, {16'd0, cur_word});
        repeat (3) @(negedge clk);
        chk("R10 hold without strobe", {16'd0, rd_data}, {16'd0, cur_word});
    endtask

    task automatic try_reserved(input logic [15:0] data);
        logic [15:0] v;
        @(negedge clk);
        op_start = 1'b1; op_kind = 2'b11; op_data = data;
        @(posedge clk);
        @(negedge clk);
        op_start = 1'b0; op_kind = 2'b00;
        for (int k = 0; k < 3; k++) begin
            chk("R3 reserved kind leaves busy low", {31'd0, busy}, 32'd0);
            @(negedge clk);
        end
        do_read(v);
        chk("R3 reserved kind keeps word", {16'd0, v}, {16'd0, cur_word});
    endtask

    initial begin
        #(CLK_P * 60000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        chk("R1 rd_data after reset", {16'd0, rd_data}, 32'd0);
        do_read(v);
        chk("R1 erased word before any op", {16'd0, v}, 32'h0000FFFF);

        try_reserved(16'h1234);

        for (int i = 0; i < 12; i++) begin
            run_op(2'b00, 16'((i * 32'h2F1B) ^ 32'h00A5), i % 3, 1'b0);
        end
        run_op(2'b01, 16'h0000, 1, 1'b0);
        run_op(2'b10, 16'h0000, 2, 1'b0);
        run_op(2'b10, 16'h0000, 1, 1'b0);
        run_op(2'b00, 16'h5A80, 1, 1'b0);
        try_reserved(16'h0000);
        run_op(2'b01, 16'h0000, 2, 1'b0);
        run_op(2'b00, 16'hC37F, 1, 1'b1);
        run_op(2'b01, 16'h0F0F, 1, 1'b1);
        run_op(2'b00, 16'h0001, 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule